// File: doc/BRIEF.md
# Comparator Timer Channel

This block is a single channel of a multi-channel event timer. A free-running 64-bit main counter is kept outside the channel, which receives its value together with a strobe that marks each cycle in which the value moved. The channel compares that value against its own comparator and emits a one-cycle interrupt pulse on a match. Global enable and interrupt routing also live outside; the channel only stores the routing field in its configuration word.

Software programs the channel through 32-bit word writes: a configuration word, the two halves of the comparator, and two ignored words (capability half and route word). The channel runs one-shot or periodic, at 64-bit or 32-bit width. In periodic mode a write to the comparator address loads the period instead, unless a one-time set-value bit was armed first. In periodic mode the comparator advances by the period on every match, and also catches up whenever it has fallen behind the counter. A 32-bit one-shot channel whose target lies beyond a counter wrap also pulses at the wrap and raises a wrap flag until the real match.

Top module: `timer_chan`

## Requirements
- R1: After reset the configuration reads 0x00000C20_00000030 (bit 4 periodic-capable, bit 5 64-bit-capable, upper word 0x00000C20), the comparator is all ones, the period is zero, the wrap flag is low and no pulse is output.
- R2: A configuration write (select 0) changes only the low-word bits under mask 0x3F4E (bit 1 trigger type, bit 2 channel enable, bit 3 periodic, bit 6 set-value, bit 8 32-bit mode, bits 13:9 route); writes to select 1 (capability word), 4 and 5 (route words) change nothing.
- R3: A configuration write with bit 8 set clears the upper 32 bits of both the comparator and the period.
- R4: A write to select 2 (comparator low) or 3 (comparator high) updates that half of the comparator when bit 3 is clear or bit 6 is set, otherwise that half of the period; either write clears bit 6.
- R5: A period write through select 2 clears bit 31 in 32-bit mode; through select 3 it clears bit 63. In 32-bit mode select 3 stores nothing, so the upper words of comparator and period stay zero.
- R6: In the cycle after a strobe in which the counter equals the comparator at the active width (all 64 bits, or the low 32 in 32-bit mode), the output pulses high for one cycle.
- R7: In periodic mode with a nonzero period, a match adds the period to the comparator, the sum wrapping at 32 bits in 32-bit mode.
- R8: In periodic mode with a nonzero period, while the signed difference counter minus comparator at the active width is positive, the comparator advances by the period on every clock without a pulse, until it is ahead.
- R9: In 32-bit one-shot mode, when a strobe brings the counter's low word to zero after a comparator write with no match since, the channel pulses and sets the wrap flag; the next match pulses again and clears the flag, and a later wrap does not pulse.
- R10: A pulse is output only when the channel enable bit and the global enable were both set in the matching cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Main counter value |
| tick_i | input | 1 | Counter holds a new value this cycle |
| glb_en_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register word write strobe |
| wr_sel_i | input | 3 | Word select: 0 config, 1 capability, 2/3 comparator low/high, 4/5 route |
| wr_data_i | input | 32 | Write data |
| cfg_o | output | 64 | Configuration and capability word |
| cmp_o | output | 64 | Comparator |
| period_o | output | 64 | Period |
| wrap_flag_o | output | 1 | Wrap pulse seen, match still pending |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume the counter changes only on strobe cycles and steps by one, so an equality test cannot skip the comparator; the bench advances the counter only through its tick task, jumping it only to values chosen so that no comparator lies in the skipped range. They also assume reset is held from time zero, which the bench does for several cycles. Stimulus is applied at falling edges and one operation at a time, so a register write never coincides with a strobe.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;
    localparam int CW = 64;
    localparam int HW = CW / 2;

    typedef enum logic [2:0] {
        SEL_CFG_LO = 3'd0,
        SEL_CFG_HI = 3'd1,
        SEL_CMP_LO = 3'd2,
        SEL_CMP_HI = 3'd3,
        SEL_RT_LO  = 3'd4,
        SEL_RT_HI  = 3'd5
    } wsel_e;

    localparam int B_EN   = 2;
    localparam int B_PER  = 3;
    localparam int B_SETV = 6;
    localparam int B_M32  = 8;

    localparam logic [HW-1:0] CFG_WMASK = 32'h0000_3F4E;
    localparam logic [CW-1:0] CFG_RST   = 64'h0000_0C20_0000_0030;

    typedef struct packed {
        logic          hit;
        logic          wrap_evt;
        logic          adv;
        logic [CW-1:0] adv_val;
    } match_t;

    function automatic logic ahead_of(input logic [CW-1:0] a,
                                      input logic [CW-1:0] b,
                                      input logic narrow);
        logic [CW-1:0] d64;
        logic [HW-1:0] d32;
        d64 = a - b;
        d32 = a[HW-1:0] - b[HW-1:0];
        return narrow ? ($signed(d32) > 0) : ($signed(d64) > 0);
    endfunction
endpackage

// File: rtl/tc_regs.sv
module tc_regs
    import timer_chan_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [HW-1:0] wr_data,
    input  logic          adv,
    input  logic [CW-1:0] adv_val,
    output logic [CW-1:0] cfg,
    output logic [CW-1:0] cmp,
    output logic [CW-1:0] period,
    output logic          cmp_wr
);
    logic [CW-1:0] cfg_n, cmp_n, per_n;
    logic          direct, narrow;

    assign direct = !cfg[B_PER] || cfg[B_SETV];
    assign narrow = cfg[B_M32];
    assign cmp_wr = wr_en && (wsel_e'(wr_sel) == SEL_CMP_LO ||
                              wsel_e'(wr_sel) == SEL_CMP_HI);

    always_comb begin
        cfg_n = cfg;
        cmp_n = adv ? adv_val : cmp;
        per_n = period;
        if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_CFG_LO: begin
                    cfg_n[HW-1:0] = (wr_data & CFG_WMASK) | (cfg[HW-1:0] & ~CFG_WMASK);
                    if (wr_data[B_M32]) begin
                        cmp_n[CW-1:HW] = '0;
                        per_n[CW-1:HW] = '0;
                    end
                end
                SEL_CMP_LO: begin
                    cfg_n[B_SETV] = 1'b0;
                    cmp_n = cmp;
                    if (direct)
                        cmp_n[HW-1:0] = wr_data;
                    else
                        per_n[HW-1:0] = narrow ? {1'b0, wr_data[HW-2:0]} : wr_data;
                end
                SEL_CMP_HI: begin
                    cfg_n[B_SETV] = 1'b0;
                    cmp_n = cmp;
                    if (!narrow) begin
                        if (direct)
                            cmp_n[CW-1:HW] = wr_data;
                        else
                            per_n[CW-1:HW] = {1'b0, wr_data[HW-2:0]};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= CFG_RST;
            cmp    <= '1;
            period <= '0;
        end else begin
            cfg    <= cfg_n;
            cmp    <= cmp_n;
            period <= per_n;
        end
    end
endmodule

// File: rtl/tc_match.sv
module tc_match
    import timer_chan_pkg::*;
(
    input  logic [CW-1:0] cnt,
    input  logic          tick,
    input  logic          narrow,
    input  logic          periodic,
    input  logic [CW-1:0] cmp,
    input  logic [CW-1:0] period,
    output match_t        m
);
    logic          eq, behind, per_on;
    logic [HW-1:0] sum32;
    logic [CW-1:0] sum64;

    always_comb begin
        eq     = narrow ? (cnt[HW-1:0] == cmp[HW-1:0]) : (cnt == cmp);
        behind = ahead_of(cnt, cmp, narrow);
        per_on = periodic && (period != '0);
        sum32  = cmp[HW-1:0] + period[HW-1:0];
        sum64  = cmp + period;
        m.hit      = tick && eq;
        m.adv      = per_on && (m.hit || behind);
        m.adv_val  = narrow ? {{HW{1'b0}}, sum32} : sum64;
        m.wrap_evt = narrow && !periodic && tick && (cnt[HW-1:0] == '0);
    end
endmodule

// File: rtl/tc_event.sv
module tc_event (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic wrap_evt,
    input  logic cmp_wr,
    input  logic ch_en,
    input  logic glb_en,
    output logic irq,
    output logic wrap_flag
);
    logic pend, wrap_fire;

    assign wrap_fire = wrap_evt && pend && !hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            wrap_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= (hit || wrap_fire) && ch_en && glb_en;
            if (cmp_wr) begin
                pend      <= 1'b1;
                wrap_flag <= 1'b0;
            end else if (hit) begin
                pend      <= 1'b0;
                wrap_flag <= 1'b0;
            end else if (wrap_fire) begin
                wrap_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/timer_chan.sv
module timer_chan
    import timer_chan_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_i,
    input  logic          tick_i,
    input  logic          glb_en_i,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_sel_i,
    input  logic [HW-1:0] wr_data_i,
    output logic [CW-1:0] cfg_o,
    output logic [CW-1:0] cmp_o,
    output logic [CW-1:0] period_o,
    output logic          wrap_flag_o,
    output logic          irq_o
);
    match_t m;
    logic   cmp_wr;

    tc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .adv     (m.adv),
        .adv_val (m.adv_val),
        .cfg     (cfg_o),
        .cmp     (cmp_o),
        .period  (period_o),
        .cmp_wr  (cmp_wr)
    );

    tc_match u_match (
        .cnt      (cnt_i),
        .tick     (tick_i),
        .narrow   (cfg_o[B_M32]),
        .periodic (cfg_o[B_PER]),
        .cmp      (cmp_o),
        .period   (period_o),
        .m        (m)
    );

    tc_event u_event (
        .clk       (clk),
        .rst       (rst),
        .hit       (m.hit),
        .wrap_evt  (m.wrap_evt),
        .cmp_wr    (cmp_wr),
        .ch_en     (cfg_o[B_EN]),
        .glb_en    (glb_en_i),
        .irq       (irq_o),
        .wrap_flag (wrap_flag_o)
    );
endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk
    import timer_chan_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] cnt_i,
    input logic          tick_i,
    input logic          glb_en_i,
    input logic          wr_en_i,
    input logic [2:0]    wr_sel_i,
    input logic [CW-1:0] cfg_o,
    input logic [CW-1:0] cmp_o,
    input logic [CW-1:0] period_o,
    input logic          wrap_flag_o,
    input logic          irq_o
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmp_o == '1 && period_o == '0 && cfg_o == CFG_RST &&
                        !wrap_flag_o && !irq_o));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && wr_sel_i == 3'd0) |=> $stable({cfg_o[CW-1:B_SETV+1], cfg_o[B_SETV-1:0]}));

    assert_setv_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (wr_sel_i == 3'd2 || wr_sel_i == 3'd3)) |=> !cfg_o[B_SETV]);

    assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_o[B_M32] |-> (cmp_o[CW-1:HW] == '0 && period_o[CW-1:HW] == '0));

    assert_period_top_R5: assert property (@(posedge clk) disable iff (rst)
        !period_o[CW-1]);

    assert_pulse_tick_R6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(tick_i));

    assert_wrap_flag_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wrap_flag_o) |-> ($past(tick_i) && $past(cnt_i[HW-1:0]) == '0));

    assert_gate_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(glb_en_i) && $past(cfg_o[B_EN])));
endmodule

bind timer_chan timer_chan_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_i       (cnt_i),
    .tick_i      (tick_i),
    .glb_en_i    (glb_en_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .cfg_o       (cfg_o),
    .cmp_o       (cmp_o),
    .period_o    (period_o),
    .wrap_flag_o (wrap_flag_o),
    .irq_o       (irq_o)
);

// File: tb/timer_chan_bench.sv
`timescale 1ns/1ps
module timer_chan_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cnt_i = '0;
    logic        tick_i = 1'b0;
    logic        glb_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [63:0] cfg_o, cmp_o, period_o;
    logic        wrap_flag_o, irq_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    timer_chan u_timer_chan (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .tick_i(tick_i),
        .glb_en_i(glb_en_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .cfg_o(cfg_o), .cmp_o(cmp_o),
        .period_o(period_o), .wrap_flag_o(wrap_flag_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic tk(input logic [63:0] v);
        @(negedge clk);
        cnt_i = v; tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 cfg", cfg_o, 64'h0000_0C20_0000_0030);
        chk("R1 cmp", cmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 period", period_o, 64'h0);
        chk("R1 wrap/irq", {62'h0, wrap_flag_o, irq_o}, 64'h0);
    endtask

    task automatic t_cfg_mask;
        wr(3'd0, 32'hFFFF_FFFF);
        chk("R2 cfg mask", cfg_o, 64'h0000_0C20_0000_3F7E);
        chk("R3 cmp truncated", cmp_o, 64'h0000_0000_FFFF_FFFF);
        wr(3'd1, 32'h1234_5678);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R2 ignored words cfg", cfg_o, 64'h0000_0C20_0000_3F7E);
        chk("R2 ignored words cmp", cmp_o, 64'h0000_0000_FFFF_FFFF);
        chk("R2 ignored words period", period_o, 64'h0);
        wr(3'd0, 32'h0);
        chk("R2 cfg clear", cfg_o, 64'h0000_0C20_0000_0030);
    endtask

    task automatic t_oneshot64;
        glb_en_i = 1'b1;
        wr(3'd0, 32'h4);
        wr(3'd3, 32'h1);
        wr(3'd2, 32'h10);
        chk("R4 one-shot loads cmp", cmp_o, 64'h0000_0001_0000_0010);
        tk(64'h10);
        chk("R6 low match only in 64-bit", {63'h0, irq_o}, 64'h0);
        tk(64'h1_0000_000F);
        chk("R6 no early pulse", {63'h0, irq_o}, 64'h0);
        tk(64'h1_0000_0010);
        chk("R6 match pulse", {63'h0, irq_o}, 64'h1);
        @(negedge clk);
        chk("R6 pulse one cycle", {63'h0, irq_o}, 64'h0);
    endtask

    task automatic t_gating;
        wr(3'd0, 32'h0);
        tk(64'h1_0000_0010);
        chk("R10 channel disabled", {63'h0, irq_o}, 64'h0);
        wr(3'd0, 32'h4);
        glb_en_i = 1'b0;
        tk(64'h1_0000_0010);
        chk("R10 global disabled", {63'h0, irq_o}, 64'h0);
        glb_en_i = 1'b1;
    endtask

    task automatic t_periodic32;
        wr(3'd0, 32'h14C);
        chk("R3 cmp truncated on 32-bit", cmp_o, 64'h10);
        chk("R2 cfg periodic", cfg_o, 64'h0000_0C20_0000_017C);
        wr(3'd2, 32'h100);
        chk("R4 set-value loads cmp", cmp_o, 64'h100);
        chk("R4 set-value cleared", cfg_o, 64'h0000_0C20_0000_013C);
        wr(3'd2, 32'h8000_0040);
        chk("R5 period bit31 cleared", period_o, 64'h40);
        chk("R4 cmp kept on period write", cmp_o, 64'h100);
        wr(3'd3, 32'hFFFF_FFFF);
        chk("R5 high write ignored in 32-bit period", period_o, 64'h40);
        chk("R5 high write ignored in 32-bit cmp", cmp_o, 64'h100);
        tk(64'h1_0000_0100);
        chk("R6 periodic pulse", {63'h0, irq_o}, 64'h1);
        chk("R7 advance", cmp_o, 64'h140);
        tk(64'h1_0000_0140);
        chk("R7 second pulse", {63'h0, irq_o}, 64'h1);
        chk("R7 second advance", cmp_o, 64'h180);
        tk(64'h1_FFFF_FFE0);
        chk("R6 no pulse off match", {63'h0, irq_o}, 64'h0);
        wr(3'd0, 32'h14C);
        wr(3'd2, 32'hFFFF_FFF0);
        tk(64'h1_FFFF_FFF0);
        chk("R7 pulse near top", {63'h0, irq_o}, 64'h1);
        chk("R7 32-bit sum wraps", cmp_o, 64'h30);
    endtask

    task automatic t_catchup;
        int pulses = 0;
        tk(64'h2_0000_0200);
        if (irq_o) pulses++;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (irq_o) pulses++;
        end
        chk("R8 catch-up result", cmp_o, 64'h230);
        chk("R8 catch-up silent", 64'(pulses), 64'h0);
    endtask

    task automatic t_wrap;
        wr(3'd0, 32'h104);
        tk(64'h2_FFFF_FFF0);
        chk("R9 no pulse before arm", {63'h0, irq_o}, 64'h0);
        wr(3'd2, 32'h5);
        tk(64'h3_0000_0000);
        chk("R9 wrap pulse", {63'h0, irq_o}, 64'h1);
        chk("R9 wrap flag set", {63'h0, wrap_flag_o}, 64'h1);
        tk(64'h3_0000_0005);
        chk("R9 match after wrap", {63'h0, irq_o}, 64'h1);
        chk("R9 wrap flag cleared", {63'h0, wrap_flag_o}, 64'h0);
        tk(64'h4_0000_0000);
        chk("R9 no second wrap pulse", {63'h0, irq_o}, 64'h0);
        wr(3'd2, 32'h10);
        tk(64'h4_0000_0010);
        chk("R9 match before wrap", {63'h0, irq_o}, 64'h1);
        tk(64'h5_0000_0000);
        chk("R9 no wrap after match", {62'h0, wrap_flag_o, irq_o}, 64'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_cfg_mask;
        t_oneshot64;
        t_gating;
        t_periodic32;
        t_catchup;
        t_wrap;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule